// File: doc/BRIEF.md
# Adder with Status Flag Generation

This block adds two operands in one clock and registers the sum together with six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. A size select picks byte or word width. In byte mode only the low bytes of the operands are used, and the upper half of the result is zero. Carry, sign, overflow and zero follow the selected width. Parity always looks at the low byte of the result. Auxiliary carry always looks at the carry out of the low nibble.

A second strobe requests a move. A move copies the second operand, cut to the selected width, into the result register and leaves the flag register as it was. This lets a datapath interleave transfers with arithmetic without disturbing the condition codes. Each accepted request produces a one-cycle valid pulse on the clock edge that captures its result. If both strobes are high in the same cycle, the add is performed.

Top module: `flag_adder`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises with no request, result, flags and result_valid are all zero.
- R2: A request (add or move) seen on a rising clock edge makes result_valid high for exactly the following cycle, with result and flags updated in that same cycle. With no request, result_valid is low.
- R3: Flag bit 0 (carry) is set after an add when there is a carry out of bit 7 in byte mode, or out of bit 15 in word mode.
- R4: Flag bit 1 (parity) is set after an add when bits 7..0 of the result hold an even number of ones. This applies in both sizes.
- R5: Flag bit 2 (auxiliary carry) is set after an add when adding bits 3..0 of the two operands carries into bit 4.
- R6: Flag bit 3 (zero) is set after an add when the result at the selected width is all zeros.
- R7: Flag bit 4 (sign) is set after an add to result bit 7 in byte mode, or to result bit 15 in word mode.
- R8: Flag bit 5 (overflow) is set after an add when both operands have the same sign bit at the selected width and the result's sign bit differs from it.
- R9: In byte mode (size_word = 0), result bits 15..8 are zero and operand bits 15..8 have no effect on result or flags.
- R10: A move (move_valid = 1, add_valid = 0) loads op_b at the selected width into result and leaves all six flags unchanged.
- R11: When add_valid and move_valid are both high, the block performs the add and sets the flags from it.
- R12: With no request, result and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend, or the move source |
| size_word | input | 1 | 1 = word width, 0 = byte width |
| add_valid | input | 1 | Add request strobe |
| move_valid | input | 1 | Move request strobe |
| result | output | 16 | Registered result |
| flags | output | 6 | Registered flags: {overflow, sign, zero, aux, parity, carry} |
| result_valid | output | 1 | One-cycle pulse for each accepted request |

## Verification
Some properties are checked by assertions on every cycle:
- the valid pulse follows one cycle after a request;
- flags stay stable across a move, and result and flags hold while idle;
- the upper result byte is zero after a byte-mode operation;
- after every add, the parity, zero and sign flags match the registered result.

The bench's scenarios cover what the registered outputs alone cannot express:
- carry and auxiliary carry, which depend on operand bits that are no longer visible;
- signed overflow at both widths;
- operand upper bytes having no effect in byte mode;
- the add winning over a move strobed in the same cycle.

// File: rtl/flag_adder_pkg.sv
package flag_adder_pkg;

    parameter int unsigned DATA_W = 16;
    parameter int unsigned HALF_W = DATA_W / 2;
    parameter int unsigned NIB_W  = 4;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } cond_t;

    localparam int unsigned COND_W = $bits(cond_t);

endpackage

// File: rtl/flag_adder_sum.sv
module flag_adder_sum
    import flag_adder_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         wide_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         cnib_o,
    output logic         ovf_o
);
    localparam int unsigned H = W / 2;

    logic [W:0]       full_sum;
    logic [H:0]       half_sum;
    logic [NIB_W:0]   nib_sum;

    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i};
        half_sum = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]};
        nib_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]};
        cnib_o   = nib_sum[NIB_W];
        if (wide_i) begin
            sum_o  = full_sum[W-1:0];
            cout_o = full_sum[W];
            ovf_o  = (a_i[W-1] == b_i[W-1]) && (full_sum[W-1] != a_i[W-1]);
        end else begin
            sum_o  = {{(W-H){1'b0}}, half_sum[H-1:0]};
            cout_o = half_sum[H];
            ovf_o  = (a_i[H-1] == b_i[H-1]) && (half_sum[H-1] != a_i[H-1]);
        end
    end

endmodule

// File: rtl/flag_adder_cond.sv
module flag_adder_cond
    import flag_adder_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] sum_i,
    input  logic         wide_i,
    input  logic         cout_i,
    input  logic         cnib_i,
    input  logic         ovf_i,
    output cond_t        cond_o
);
    localparam int unsigned H = W / 2;

    logic [H:0] par_chain;

    assign par_chain[0] = 1'b0;
    for (genvar g = 0; g < H; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ sum_i[g];
    end

    always_comb begin
        cond_o.cry = cout_i;
        cond_o.par = ~par_chain[H];
        cond_o.aux = cnib_i;
        cond_o.zro = wide_i ? (sum_i == '0) : (sum_i[H-1:0] == '0);
        cond_o.sgn = wide_i ? sum_i[W-1] : sum_i[H-1];
        cond_o.ovf = ovf_i;
    end

endmodule

// File: rtl/flag_adder.sv
module flag_adder
    import flag_adder_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              size_word,
    input  logic              add_valid,
    input  logic              move_valid,
    output logic [DATA_W-1:0] result,
    output logic [COND_W-1:0] flags,
    output logic              result_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        cond_t             cond;
        logic              vld;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] sum_w;
    logic              cout_w, cnib_w, ovf_w;
    cond_t             cond_w;
    logic [DATA_W-1:0] move_w;

    flag_adder_sum #(.W(DATA_W)) i_sum (
        .a_i   (op_a),
        .b_i   (op_b),
        .wide_i(size_word),
        .sum_o (sum_w),
        .cout_o(cout_w),
        .cnib_o(cnib_w),
        .ovf_o (ovf_w)
    );

    flag_adder_cond #(.W(DATA_W)) i_cond (
        .sum_i (sum_w),
        .wide_i(size_word),
        .cout_i(cout_w),
        .cnib_i(cnib_w),
        .ovf_i (ovf_w),
        .cond_o(cond_w)
    );

    assign move_w = size_word ? op_b : {{(DATA_W-HALF_W){1'b0}}, op_b[HALF_W-1:0]};

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (add_valid) begin
            st_d.res  = sum_w;
            st_d.cond = cond_w;
            st_d.vld  = 1'b1;
        end else if (move_valid) begin
            st_d.res = move_w;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.res;
    assign flags        = st_q.cond;
    assign result_valid = st_q.vld;

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (result_valid == $past(add_valid || move_valid)));

    assert_move_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && !add_valid) |=> $stable(flags));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!move_valid && !add_valid) |=> ($stable(flags) && $stable(result) && !result_valid));

    assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((add_valid || move_valid) && !size_word) |=> (result[DATA_W-1:HALF_W] == '0));

    assert_parity_low_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        add_valid |=> (flags[1] == ~(^result[HALF_W-1:0])));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        add_valid |=> (flags[3] == (result == '0)));

    assert_sign_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (add_valid && size_word) |=> (flags[4] == result[DATA_W-1]));

    assert_sign_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (add_valid && !size_word) |=> (flags[4] == result[HALF_W-1]));

endmodule

// File: tb/test_flag_adder.sv
module test_flag_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        size_word = 1'b0, add_valid = 1'b0, move_valid = 1'b0;
    logic [15:0] result;
    logic [5:0]  flags;
    logic        result_valid;

    int errors = 0;
    int checks = 0;
    int exp_res = 0;
    int exp_flags = 0;
    int exp_vld = 0;

    always #10 clk = ~clk;

    flag_adder i_flag_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .size_word(size_word),
        .add_valid(add_valid), .move_valid(move_valid),
        .result(result), .flags(flags), .result_valid(result_valid)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "result", int'(result), exp_res);
        check(tag, "flags", int'(flags), exp_flags);
        check(tag, "valid", int'(result_valid), exp_vld);
    endtask

    task automatic step(bit add, bit mov, bit word, int a, int b, string tag);
        int mask, top, x, y, s, r, cf, af, sf, of, zf, pf;
        add_valid = add; move_valid = mov; size_word = word;
        op_a = a[15:0]; op_b = b[15:0];
        @(posedge clk);
        mask = word ? 'hFFFF : 'hFF;
        top  = word ? 15 : 7;
        x = a & mask; y = b & mask;
        if (add) begin
            s  = x + y;
            r  = s & mask;
            cf = (s >> (top + 1)) & 1;
            af = (((x & 15) + (y & 15)) > 15) ? 1 : 0;
            sf = (r >> top) & 1;
            of = ((((x >> top) & 1) == ((y >> top) & 1)) && (sf != ((x >> top) & 1))) ? 1 : 0;
            zf = (r == 0) ? 1 : 0;
            pf = ($countones(r & 255) % 2 == 0) ? 1 : 0;
            exp_res = r;
            exp_flags = (of << 5) | (sf << 4) | (zf << 3) | (af << 2) | (pf << 1) | cf;
        end else if (mov) begin
            exp_res = y;
        end
        exp_vld = (add || mov) ? 1 : 0;
        @(negedge clk);
        add_valid = 1'b0; move_valid = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
        step(1, 0, 1, 'h1234, 'h4321, "R2");
        step(0, 0, 1, 0, 0, "R2");
        step(1, 0, 0, 'h00FF, 'h0001, "R3_R6");
        step(1, 0, 1, 'hFFFF, 'h0001, "R3_R6");
        step(1, 0, 1, 'h00F0, 'h0010, "R3");
        step(1, 0, 1, 'h0003, 'h0000, "R4");
        step(1, 0, 1, 'h0100, 'h0000, "R4");
        step(1, 0, 0, 'h0008, 'h0008, "R5");
        step(1, 0, 1, 'h0007, 'h0008, "R5");
        step(1, 0, 0, 'h0040, 'h0040, "R7_R8");
        step(1, 0, 1, 'h7000, 'h1000, "R7_R8");
        step(1, 0, 1, 'h8000, 'h8000, "R8");
        step(1, 0, 0, 'h0080, 'h0080, "R8");
        step(1, 0, 0, 'hAB12, 'hCD34, "R9");
        step(1, 0, 0, 'h0012, 'h0034, "R9");
        step(1, 0, 1, 'h8001, 'h8000, "R10");
        step(0, 1, 1, 0, 'hBEEF, "R10");
        step(0, 1, 0, 0, 'h5A00, "R10");
        step(0, 0, 0, 0, 0, "R12");
        step(1, 1, 1, 'h0101, 'h0202, "R11");
        step(0, 0, 1, 'hFFFF, 'hFFFF, "R12");
        for (int i = 0; i < 64; i++)
            step(1, 0, i[0], (i * 1237 + 91) & 'hFFFF, (i * 7919 + 33) & 'hFFFF, "R3_R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule